// File: doc/BRIEF.md
# Response Receive Queue with CRC Check

This block sits between a serial bus receiver and a host register interface. A bus slave answers with a response frame that arrives one bit per bus clock. The frame carries an 8-bit payload followed by a 4-bit CRC. The block gathers the bits and recomputes the CRC over the payload. It then stores the payload, without its CRC bits, together with a one-bit CRC-error flag as a single queue entry.

The host runs on its own clock, which has no fixed relation to the bus clock. It pops entries one at a time with a read request, and each read returns the payload and its error flag together. The queue holds four entries. Its pointers cross between the two clock domains as Gray code.

When the queue turns non-empty while interrupts are enabled, an active-low drive enable is asserted. This drive enable can pull a shared, wired interrupt line low.

Top module: `rsp_rx_queue`

## Requirements
- R1: A frame is 12 bits, sampled on rising `bus_clk` edges while `rx_en` is high, most significant bit first: 8 payload bits, then 4 CRC bits. If `rx_en` drops before the 12th bit, the partial frame is discarded and the next frame starts from bit zero.
- R2: The CRC uses generator x^4+x+1 with initial value 0, shifted most significant bit first over the payload. The stored entry holds the 8 payload bits, with the CRC bits removed, and an error flag that is 1 exactly when the received CRC differs from the recomputed one.
- R3: Up to four entries are held, and reads return them in arrival order.
- R4: A frame completed while four entries are held is dropped and the held entries stay unchanged. The `overflow` output is then set and stays set until reset.
- R5: A read while the queue is empty returns `rd_data`=0 and `rd_err`=0 and removes nothing.
- R6: `rd_data` and `rd_err` are registered. They change only at a `host_clk` edge where `rd_req` is high, and hold their value otherwise.
- R7: `rd_empty` is 1 when no unread entry is visible to the host. It falls within a few `host_clk` cycles after a frame is stored, and rises at the edge that takes the last entry.
- R8: `irq_drv_n` goes low after the queue changes from empty to non-empty while `int_en` is 1. It returns high once the queue is empty again or `int_en` is 0. Enabling `int_en` while the queue is already non-empty raises no request.
- R9: While `rst_n` is low, the queue and all outputs clear: `rd_empty`=1, `irq_drv_n`=1, `overflow`=0, `rd_data`=0, `rd_err`=0. Read requests and bus bits presented during reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_en | input | 1 | Frame bit valid |
| rx_bit | input | 1 | Serial frame bit, MSB first |
| overflow | output | 1 | Sticky flag: a frame was dropped because the queue was full (bus domain) |
| host_clk | input | 1 | Host-side clock |
| rd_req | input | 1 | Pop one entry |
| int_en | input | 1 | Interrupt enable |
| rd_data | output | 8 | Payload of the popped entry |
| rd_err | output | 1 | CRC-error flag of the popped entry |
| rd_empty | output | 1 | No entry available to the host |
| irq_drv_n | output | 1 | Active-low interrupt drive enable |

## Verification
Two functions can fall in the same cycle: storing a completed frame and popping an entry, each in its own clock domain. The bench provokes this by running a host reader that pops whenever `rd_empty` is low while frames stream in back to back. The result is judged on the order and content of every popped entry and on `overflow` staying clear. A second case, a drop on a full queue, is checked against the four kept entries and an empty read that follows them.

// File: rtl/rspq_pkg.sv
package rspq_pkg;

  localparam int unsigned CRC_MAXW = 16;
  typedef logic [CRC_MAXW-1:0] crc_word_t;

  // One MSB-first shift of a CRC register of 'width' bits.
  function automatic crc_word_t crc_shift(input crc_word_t state, input logic din,
                                          input crc_word_t poly, input int unsigned width);
    crc_word_t mask;
    crc_word_t tmp;
    crc_word_t nxt;
    logic      fb;
    mask = crc_word_t'((32'd1 << width) - 32'd1);
    tmp  = state >> (width - 1);
    fb   = tmp[0] ^ din;
    nxt  = (state << 1) & mask;
    if (fb) nxt = nxt ^ (poly & mask);
    return nxt;
  endfunction

endpackage

// File: rtl/rspq_capture.sv
module rspq_capture
  import rspq_pkg::*;
#(
  parameter int unsigned         PAY_W    = 8,
  parameter int unsigned         CRC_W    = 4,
  parameter logic [CRC_W-1:0]    CRC_POLY = 4'h3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_bit,
  output logic             frm_done,
  output logic [PAY_W-1:0] frm_pay,
  output logic             frm_err
);

  localparam int unsigned FRAME_W = PAY_W + CRC_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic               last_bit;
  logic [CRC_W-1:0]   rx_crc;
  logic [CRC_W-1:0]   calc_crc;

  function automatic logic [CRC_W-1:0] payload_crc(input logic [PAY_W-1:0] pay);
    crc_word_t st;
    st = '0;
    for (int i = PAY_W - 1; i >= 0; i--)
      st = crc_shift(st, pay[i], crc_word_t'(CRC_POLY), CRC_W);
    return st[CRC_W-1:0];
  endfunction

  assign last_bit = rx_en && (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      frm_done <= 1'b0;
    end else begin
      frm_done <= last_bit;
      if (rx_en) begin
        shreg   <= {shreg[FRAME_W-2:0], rx_bit};
        bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
      end else begin
        bit_cnt <= '0;
      end
    end
  end

  assign frm_pay  = shreg[FRAME_W-1:CRC_W];
  assign rx_crc   = shreg[CRC_W-1:0];
  assign calc_crc = payload_crc(frm_pay);
  assign frm_err  = (calc_crc != rx_crc);

  AST_DONE_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> ($past(rx_en) && $past(bit_cnt) == CNT_W'(FRAME_W - 1))); // R1
  AST_IDLE_RESTARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !frm_done); // R1

endmodule

// File: rtl/rspq_sync2.sv
module rspq_sync2 #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/rspq_afifo.sv
module rspq_afifo #(
  parameter int unsigned PAY_W      = 8,
  parameter int unsigned DEPTH_LOG2 = 2
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PAY_W-1:0] push_pay,
  input  logic             push_err,
  output logic             overflow,
  input  logic             rd_req,
  output logic [PAY_W-1:0] rd_data,
  output logic             rd_err,
  output logic             rd_empty
);

  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
  localparam int unsigned PW    = DEPTH_LOG2 + 1;
  localparam int unsigned ENT_W = PAY_W + 1;

  logic [ENT_W-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rgray_w, rbin_w;
  logic [PW-1:0] rbin, rgray, wgray_r, wbin_r;
  logic          full, wr_accept, wr_drop, rd_take;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write side (bus clock) ----------------
  rspq_sync2 #(.W(PW)) u_rd2wr (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

  assign rbin_w    = from_gray(rgray_w);
  assign full      = ((wbin ^ rbin_w) == {1'b1, {DEPTH_LOG2{1'b0}}});
  assign wr_accept = push && !full;
  assign wr_drop   = push && full;

  always_ff @(posedge wr_clk) begin
    if (wr_accept) mem[wbin[DEPTH_LOG2-1:0]] <= {push_err, push_pay};
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_accept) begin
        wbin  <= wbin + PW'(1);
        wgray <= to_gray(wbin + PW'(1));
      end
      if (wr_drop) overflow <= 1'b1;
    end
  end

  AST_DROP_KEEPS_WPTR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_drop |=> $stable(wbin)); // R4
  AST_OVERFLOW_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
    overflow |=> overflow); // R4
  AST_WR_LEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin - rbin_w) <= PW'(DEPTH)); // R3

  // ---------------- read side (host clock) ----------------
  rspq_sync2 #(.W(PW)) u_wr2rd (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  assign wbin_r   = from_gray(wgray_r);
  assign rd_empty = (rbin == wbin_r);
  assign rd_take  = rd_req && !rd_empty;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else if (rd_req) begin
      if (rd_take) begin
        {rd_err, rd_data} <= mem[rbin[DEPTH_LOG2-1:0]];
        rbin  <= rbin + PW'(1);
        rgray <= to_gray(rbin + PW'(1));
      end else begin
        rd_data <= '0;
        rd_err  <= 1'b0;
      end
    end
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_req && rd_empty) |=> (rd_data == '0 && !rd_err && $stable(rbin))); // R5
  AST_RD_HOLDS_IDLE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_req |=> ($stable(rd_data) && $stable(rd_err))); // R6
  AST_RD_LEVEL_BOUND: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (wbin_r - rbin) <= PW'(DEPTH)); // R3

endmodule

// File: rtl/rspq_irq.sv
module rspq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic q_empty,
  input  logic int_en,
  output logic irq_drv_n
);

  logic ne_q;
  logic pend;
  logic became_ne;

  assign became_ne = !q_empty && !ne_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      ne_q <= !q_empty;
      if (q_empty || !int_en) pend <= 1'b0;
      else if (became_ne)     pend <= 1'b1;
    end
  end

  assign irq_drv_n = !pend;

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_drv_n) |-> ($past(int_en) && !$past(q_empty))); // R8
  AST_IRQ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty || !int_en) |=> irq_drv_n); // R8

endmodule

// File: rtl/rsp_rx_queue.sv
module rsp_rx_queue #(
  parameter int unsigned      PAY_W      = 8,
  parameter int unsigned      CRC_W      = 4,
  parameter logic [CRC_W-1:0] CRC_POLY   = 4'h3,
  parameter int unsigned      DEPTH_LOG2 = 2
) (
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_bit,
  output logic             overflow,
  input  logic             host_clk,
  input  logic             rd_req,
  input  logic             int_en,
  output logic [PAY_W-1:0] rd_data,
  output logic             rd_err,
  output logic             rd_empty,
  output logic             irq_drv_n
);

  logic             frm_done;
  logic [PAY_W-1:0] frm_pay;
  logic             frm_err;

  rspq_capture #(.PAY_W(PAY_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_capture (
    .clk      (bus_clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_bit   (rx_bit),
    .frm_done (frm_done),
    .frm_pay  (frm_pay),
    .frm_err  (frm_err)
  );

  rspq_afifo #(.PAY_W(PAY_W), .DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .wr_clk   (bus_clk),
    .rd_clk   (host_clk),
    .rst_n    (rst_n),
    .push     (frm_done),
    .push_pay (frm_pay),
    .push_err (frm_err),
    .overflow (overflow),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .rd_empty (rd_empty)
  );

  rspq_irq u_irq (
    .clk       (host_clk),
    .rst_n     (rst_n),
    .q_empty   (rd_empty),
    .int_en    (int_en),
    .irq_drv_n (irq_drv_n)
  );

endmodule

// File: tb/test_rsp_rx_queue.sv
`timescale 1ns/1ps
module test_rsp_rx_queue;

  logic       bus_clk = 1'b0;
  logic       host_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_bit = 1'b0;
  logic       rd_req = 1'b0;
  logic       int_en = 1'b0;
  logic       overflow, rd_err, rd_empty, irq_drv_n;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  always #10   bus_clk  = ~bus_clk;   // 50 MHz
  always #6.5  host_clk = ~host_clk;  // unrelated host clock

  rsp_rx_queue i_rsp_rx_queue (
    .bus_clk(bus_clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .overflow(overflow), .host_clk(host_clk), .rd_req(rd_req), .int_en(int_en),
    .rd_data(rd_data), .rd_err(rd_err), .rd_empty(rd_empty), .irq_drv_n(irq_drv_n)
  );

  function automatic logic [3:0] exp_crc(input logic [7:0] pay);
    logic [11:0] v;
    v = {pay, 4'h0};
    for (int i = 11; i >= 4; i--)
      if (v[i]) v[i -: 5] = v[i -: 5] ^ 5'b10011;
    return v[3:0];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_host(input int n);
    repeat (n) @(negedge host_clk);
  endtask

  task automatic send_bits(input logic [11:0] frame, input int nbits);
    for (int i = 11; i > 11 - nbits; i--) begin
      @(negedge bus_clk);
      rx_en  = 1'b1;
      rx_bit = frame[i];
    end
    @(negedge bus_clk);
    rx_en  = 1'b0;
    rx_bit = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] pay, input logic [3:0] crc);
    send_bits({pay, crc}, 12);
  endtask

  task automatic host_read(output logic [7:0] d, output logic e);
    @(negedge host_clk);
    rd_req = 1'b1;
    @(negedge host_clk);
    rd_req = 1'b0;
    d = rd_data;
    e = rd_err;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    int_en = 1'b0;
    // stimulus during reset must have no effect (R9)
    rd_req = 1'b1;
    rx_en  = 1'b1;
    rx_bit = 1'b1;
    repeat (14) @(negedge bus_clk);
    rd_req = 1'b0;
    rx_en  = 1'b0;
    rx_bit = 1'b0;
    @(negedge bus_clk);
    rst_n = 1'b1;
    wait_host(4);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic       e;

    // ---------- reset state ----------
    do_reset();
    check("R9 rd_empty after reset", rd_empty, 1);
    check("R9 irq_drv_n after reset", irq_drv_n, 1);
    check("R9 overflow after reset", overflow, 0);
    check("R9 rd_data after reset", rd_data, 0);
    check("R9 rd_err after reset", rd_err, 0);

    // ---------- empty read ----------
    host_read(d, e);
    check("R5 empty read data", d, 0);
    check("R5 empty read err", e, 0);
    check("R5 still empty", rd_empty, 1);

    // ---------- full payload sweep, good and corrupted CRC ----------
    int_en = 1'b1;
    for (int g = 0; g < 64; g++) begin
      for (int k = 0; k < 4; k++) begin
        int p;
        logic [3:0] c;
        p = g * 4 + k;
        c = exp_crc(8'(p));
        if (p % 3 == 0) c = c ^ (4'h1 << (p % 4));
        send_frame(8'(p), c);
        if (k == 0) begin
          wait_host(8);
          check("R7 non-empty after store", rd_empty, 0);
          check("R8 irq on empty to non-empty", irq_drv_n, 0);
        end
      end
      wait_host(8);
      check("R4 no overflow at exactly four", overflow, 0);
      for (int k = 0; k < 4; k++) begin
        int p;
        p = g * 4 + k;
        host_read(d, e);
        check("R2 R3 payload order", d, p);
        check("R2 crc error flag", e, (p % 3 == 0) ? 1 : 0);
      end
      wait_host(3);
      check("R7 empty after drain", rd_empty, 1);
      check("R8 irq released when empty", irq_drv_n, 1);
    end

    // ---------- read port holds value (R6) ----------
    send_frame(8'h5A, exp_crc(8'h5A));
    wait_host(8);
    check("R6 rd_data held without rd_req", rd_data, 8'hFF);
    host_read(d, e);
    check("R6 rd_data after read", d, 8'h5A);
    wait_host(5);
    check("R6 rd_data still held", rd_data, 8'h5A);

    // ---------- partial frame discarded (R1) ----------
    send_bits(12'hFFF, 7);
    send_frame(8'h3C, exp_crc(8'h3C));
    wait_host(8);
    host_read(d, e);
    check("R1 frame after partial data", d, 8'h3C);
    check("R1 frame after partial err", e, 0);
    wait_host(2);
    check("R1 partial frame not stored", rd_empty, 1);

    // ---------- overflow (R4) ----------
    for (int i = 0; i < 5; i++) send_frame(8'(8'h10 + i), exp_crc(8'(8'h10 + i)));
    wait_host(8);
    check("R4 overflow set", overflow, 1);
    for (int i = 0; i < 4; i++) begin
      host_read(d, e);
      check("R4 kept entries", d, 8'h10 + i);
    end
    host_read(d, e);
    check("R4 R5 dropped frame absent", d, 0);
    wait_host(2);
    check("R4 overflow sticky", overflow, 1);

    // ---------- interrupt enable rules (R8) ----------
    do_reset();
    check("R9 overflow cleared by reset", overflow, 0);
    send_frame(8'h77, exp_crc(8'h77));
    wait_host(8);
    check("R8 no irq when disabled", irq_drv_n, 1);
    int_en = 1'b1;
    wait_host(3);
    check("R8 late enable raises nothing", irq_drv_n, 1);
    host_read(d, e);
    check("R8 drain entry", d, 8'h77);
    send_frame(8'h88, exp_crc(8'h88));
    wait_host(8);
    check("R8 irq with enable", irq_drv_n, 0);
    int_en = 1'b0;
    wait_host(2);
    check("R8 irq released by disable", irq_drv_n, 1);
    host_read(d, e);

    // ---------- concurrent store and pop ----------
    do_reset();
    int_en = 1'b1;
    fork
      begin
        for (int i = 0; i < 12; i++) begin
          logic [3:0] c;
          c = exp_crc(8'(8'hA0 + i));
          if (i == 11) c = ~c;
          send_frame(8'(8'hA0 + i), c);
        end
      end
      begin
        for (int n = 0; n < 12; ) begin
          @(negedge host_clk);
          if (!rd_empty) begin
            host_read(d, e);
            check("R3 concurrent order", d, 8'hA0 + n);
            check("R2 concurrent err", e, (n == 11) ? 1 : 0);
            n++;
          end
        end
      end
    join
    wait_host(8);
    check("R4 no overflow while draining", overflow, 0);
    check("R7 empty at end", rd_empty, 1);

    done_flag = 1;
    finish_run();
  end

endmodule